// File: doc/BRIEF.md
# Interlocked Converter Control Register Bank

This block holds the configuration and status words of a data-converter peripheral behind a simple 16-bit word bus. Software reads and writes the words by byte offset. The bank also decides which writes may land. It leaves out the converter datapath, transfer engine and interrupt logic. It only stores the words, supplies their reset values, filters writes, and keeps the power lock status up to date.

Protection has two levels. An arm bit freezes the words that shape a conversion: the control words 0, 1, 2 and 7, both window thresholds and the transfer destination address. A lock status bit follows the converter's power state and freezes the word that holds the arm bit. A trigger-select bit picks the power source. It is either a software on bit or an external power-up input, and the external input passes through a synchroniser and a detect flop first. To unlock, software first removes power, then clears the arm bit, and only then may it rewrite the configuration.

The converter side loads a sample word through a valid/data pair. That word is read-only from the bus. The lock status also drives an output to the converter.

Top module: `cvt_ctrl_regbank`

## Requirements
- R1: After reset the words read as follows. Control word 0 (offset 10h) reads 8001h, control word 6 (1Ch) reads 0019h and control word 7 (1Eh) reads 000Fh. The descriptor words at 0Ch and 0Eh read 0110h and BB10h. Every other listed word reads 0.
- R2: Control words 0 to 7 sit at byte offsets 10h, 12h, and so on up to 1Eh. The sample word sits at 22h, the high window threshold at 24h, the low window threshold at 26h and the transfer address at 28h. Any other offset, odd offsets included, reads 0 and ignores writes. bus_rdata is 0 unless bus_sel=1 and bus_wr=0.
- R3: While the arm bit (bit 0 of control word 3) is 1, writes to control words 0, 1, 2 and 7, to both thresholds and to the transfer address change nothing. Reads of these words still return their contents, and no error is raised.
- R4: While the lock status is 1, writes to control word 3 change nothing, so the arm bit cannot be cleared.
- R5: The lock status reads back as bit 0 of control word 5, and writes cannot alter it. Bits 15:1 of control word 5 are ordinary storage.
- R6: When the trigger-select bit (bit 0 of control word 0) is 0, the lock status equals the on bit (bit 0 of control word 4). Writing the on bit as 1 sets the lock at the same clock edge that stores the write.
- R7: When the trigger-select bit is 1, the lock status follows ext_pwr_up through two synchroniser flops and one detect flop. The lock becomes 1 at the third rising edge at which the input is sampled high, which stays within the 4-cycle limit.
- R8: The lock clears in the first cycle in which the selected source is inactive: right after the on bit is written 0, or at the third edge at which ext_pwr_up is sampled low. Once the lock has cleared, the arm bit can be cleared and the protected words accept writes again.
- R9: The sample word at 22h loads cvt_data at each rising edge where cvt_valid=1. Bus writes to it have no effect.
- R10: Control words 4 and 6, bits 15:1 of control word 5, and control word 3 while unlocked accept writes at any time, whatever the arm bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| ext_pwr_up | input | 1 | External power-up request, asynchronous |
| cvt_valid | input | 1 | Converter sample strobe |
| cvt_data | input | 16 | Converter sample word |
| cvt_locked | output | 1 | Lock status, meaning the converter is powered |

## Verification
The bench builds the block with the default ADDR_W=6 and SYNC_N=2. At these values every listed and reserved offset can be reached, and the external path takes exactly three edges, so the bench can sample the lock at each of those edges and see the moment it sets and clears. Seeded random traffic hits control words 0, 3 and 4 often, and ext_pwr_up toggles now and then. This moves the bank through armed, software-locked and externally locked states while writes keep landing on protected words.

// File: rtl/cvt_ctrl_pkg.sv
package cvt_ctrl_pkg;

  localparam int DW    = 16;
  localparam int NSLOT = 14;

  // slot indices
  localparam int SL_CTL0 = 0;
  localparam int SL_CTL3 = 3;
  localparam int SL_CTL4 = 4;
  localparam int SL_CTL5 = 5;
  localparam int SL_DATA = 8;
  localparam int SL_WHI  = 9;
  localparam int SL_WLO  = 10;
  localparam int SL_DMA  = 11;
  localparam int SL_DLO  = 12;
  localparam int SL_DHI  = 13;

  // control bit positions
  localparam int TRIG_BIT = 0;
  localparam int ARM_BIT  = 0;
  localparam int ON_BIT   = 0;
  localparam int LOCK_BIT = 0;

  // byte offset of a slot
  function automatic int slot_offset(int s);
    if (s < SL_DATA) return 'h10 + 2 * s;
    case (s)
      SL_DATA: return 'h22;
      SL_WHI:  return 'h24;
      SL_WLO:  return 'h26;
      SL_DMA:  return 'h28;
      SL_DLO:  return 'h0C;
      default: return 'h0E;
    endcase
  endfunction

  function automatic logic [DW-1:0] slot_reset(int s);
    case (s)
      SL_CTL0: return 16'h8001;
      6:       return 16'h0019;
      7:       return 16'h000F;
      SL_DLO:  return 16'h0110;
      SL_DHI:  return 16'hBB10;
      default: return '0;
    endcase
  endfunction

  // bits software may write
  function automatic logic [DW-1:0] slot_wmask(int s);
    case (s)
      SL_CTL5:                return ~(DW'(1) << LOCK_BIT);
      SL_DATA, SL_DLO, SL_DHI: return '0;
      default:                return '1;
    endcase
  endfunction

  // frozen while armed
  function automatic logic slot_arm_guarded(int s);
    return (s <= 2) || (s == 7) || (s == SL_WHI) || (s == SL_WLO) || (s == SL_DMA);
  endfunction

  // frozen while locked
  function automatic logic slot_lock_guarded(int s);
    return s == SL_CTL3;
  endfunction

  function automatic logic [DW-1:0] write_merge(logic [DW-1:0] old_v,
                                                logic [DW-1:0] new_v,
                                                logic [DW-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  // word as seen on the bus
  function automatic logic [DW-1:0] slot_view(int s, logic [DW-1:0] q, logic lock);
    if (s == SL_CTL5) return q | (DW'(lock) << LOCK_BIT);
    return q;
  endfunction

endpackage

// File: rtl/cvt_addr_dec.sv
module cvt_addr_dec
  import cvt_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NSLOT-1:0]  hit
);

  for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(slot_offset(s));
    assign hit[s] = (addr == OFS);
  end

endmodule

// File: rtl/cvt_pwr_lock.sv
module cvt_pwr_lock #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  input  logic trig_sel,
  input  logic on_bit,
  output logic locked
);

  logic [SYNC_N-1:0] sync_q;
  logic              det_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      det_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], ext_in};
      det_q  <= sync_q[SYNC_N-1];
    end
  end

  // software source acts at once, external source after the detect flop
  assign locked = trig_sel ? det_q : on_bit;

endmodule

// File: rtl/cvt_ctrl_regbank.sv
module cvt_ctrl_regbank
  import cvt_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              ext_pwr_up,
  input  logic              cvt_valid,
  input  logic [DW-1:0]     cvt_data,
  output logic              cvt_locked
);

  logic [NSLOT-1:0]         hit;
  logic [NSLOT-1:0][DW-1:0] reg_q;
  logic [DW-1:0]            rd_val;
  logic                     wr_stb;
  logic                     rd_stb;
  logic                     armed;
  logic                     locked;
  logic                     trig_sel;
  logic                     on_bit;

  assign wr_stb   = bus_sel & bus_wr;
  assign rd_stb   = bus_sel & ~bus_wr;
  assign armed    = reg_q[SL_CTL3][ARM_BIT];
  assign trig_sel = reg_q[SL_CTL0][TRIG_BIT];
  assign on_bit   = reg_q[SL_CTL4][ON_BIT];

  cvt_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  cvt_pwr_lock #(.SYNC_N(SYNC_N)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_in   (ext_pwr_up),
    .trig_sel (trig_sel),
    .on_bit   (on_bit),
    .locked   (locked)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [DW-1:0] RST_V = slot_reset(s);
    localparam logic [DW-1:0] WMASK = slot_wmask(s);
    localparam logic          ARMG  = slot_arm_guarded(s);
    localparam logic          LOCKG = slot_lock_guarded(s);

    if (s == SL_DATA) begin : g_sample
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= RST_V;
        else if (cvt_valid) q <= cvt_data;
      end
      assign reg_q[s] = q;
    end else if (WMASK == '0) begin : g_const
      assign reg_q[s] = RST_V;
    end else begin : g_rw
      logic          wr_ok;
      logic [DW-1:0] q;
      assign wr_ok = wr_stb & hit[s]
                   & ~(armed & ARMG)
                   & ~(locked & LOCKG);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= RST_V;
        else if (wr_ok) q <= write_merge(q, bus_wdata, WMASK);
      end
      assign reg_q[s] = q;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (hit[s]) rd_val = rd_val | slot_view(s, reg_q[s], locked);
    end
    bus_rdata = rd_stb ? rd_val : '0;
  end

  assign cvt_locked = locked;

endmodule

// File: rtl/cvt_ctrl_regbank_chk.sv
module cvt_ctrl_regbank_chk
  import cvt_ctrl_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic                wr_lsb,
  input logic [DW-1:0]       bus_rdata,
  input logic                ext_pwr_up,
  input logic                cvt_valid,
  input logic [NSLOT-1:0]    hit,
  input logic                armed,
  input logic                locked,
  input logic                trig_sel,
  input logic [7*DW-1:0]     guard_vals,
  input logic [DW-1:0]       arm_reg,
  input logic [DW-1:0]       data_reg
);

  logic [2:0] hi_cnt;
  logic [2:0] lo_cnt;
  logic       wr_any;
  logic       guard_hit;

  assign wr_any    = bus_sel & bus_wr;
  assign guard_hit = hit[0] | hit[1] | hit[2] | hit[7] | hit[SL_WHI] | hit[SL_WLO] | hit[SL_DMA];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= ext_pwr_up  ? ((hi_cnt == 3'd7) ? hi_cnt : 3'(hi_cnt + 3'd1)) : 3'd0;
      lo_cnt <= !ext_pwr_up ? ((lo_cnt == 3'd7) ? lo_cnt : 3'(lo_cnt + 3'd1)) : 3'd0;
    end
  end

  a_r2_reserved_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && hit == '0) |-> bus_rdata == '0);

  a_r3_armed_words_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && armed && guard_hit) |=> $stable(guard_vals));

  a_r4_lock_freezes_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && locked && hit[SL_CTL3]) |=> $stable(arm_reg));

  a_r5_lock_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && hit[SL_CTL5]) |-> bus_rdata[LOCK_BIT] == locked);

  a_r6_sw_on_sets_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && hit[SL_CTL4] && wr_lsb && !trig_sel) |=> locked);

  a_r7_ext_lock_in_time: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel && hi_cnt >= 3'd4) |-> locked);

  a_r8_ext_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel && lo_cnt >= 3'd4) |-> !locked);

  a_r8_sw_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && hit[SL_CTL4] && !wr_lsb && !trig_sel) |=> !locked);

  a_r9_sample_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && hit[SL_DATA] && !cvt_valid) |=> $stable(data_reg));

endmodule

bind cvt_ctrl_regbank cvt_ctrl_regbank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .wr_lsb     (bus_wdata[0]),
  .bus_rdata  (bus_rdata),
  .ext_pwr_up (ext_pwr_up),
  .cvt_valid  (cvt_valid),
  .hit        (hit),
  .armed      (armed),
  .locked     (locked),
  .trig_sel   (trig_sel),
  .guard_vals ({reg_q[0], reg_q[1], reg_q[2], reg_q[7], reg_q[9], reg_q[10], reg_q[11]}),
  .arm_reg    (reg_q[3]),
  .data_reg   (reg_q[8])
);

// File: tb/cvt_ctrl_regbank_bench.sv
module cvt_ctrl_regbank_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ext_pwr_up = 1'b0;
  logic        cvt_valid = 1'b0;
  logic [15:0] cvt_data = '0;
  logic        cvt_locked;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [15:0] bm [14];
  logic        e1 = 1'b0, e2 = 1'b0, e3 = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cvt_ctrl_regbank u_cvt_ctrl_regbank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_pwr_up(ext_pwr_up), .cvt_valid(cvt_valid), .cvt_data(cvt_data),
    .cvt_locked(cvt_locked)
  );

  // offset -> model index, -1 when reserved (R2)
  function automatic int b_slot(logic [5:0] a);
    int v = int'(a);
    if (v >= 16 && v <= 30 && v % 2 == 0) return (v - 16) / 2;
    case (v)
      34: return 8;
      36: return 9;
      38: return 10;
      40: return 11;
      12: return 12;
      14: return 13;
      default: return -1;
    endcase
  endfunction

  function automatic logic [15:0] b_reset(int k);
    case (k)
      0: return 16'h8001;
      6: return 16'h0019;
      7: return 16'h000F;
      12: return 16'h0110;
      13: return 16'hBB10;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] b_mask(int k);
    if (k == 5) return 16'hFFFE;
    if (k == 8 || k == 12 || k == 13) return 16'h0000;
    return 16'hFFFF;
  endfunction

  function automatic bit b_guard(int k);
    return k inside {0, 1, 2, 7, 9, 10, 11};
  endfunction

  function automatic logic b_lock();
    return bm[0][0] ? e3 : bm[4][0];
  endfunction

  function automatic logic [15:0] b_read(logic [5:0] a);
    int k = b_slot(a);
    if (k < 0) return 16'h0000;
    if (k == 5) return bm[5] | {15'b0, b_lock()};
    return bm[k];
  endfunction

  function automatic string b_tag(logic [5:0] a);
    int k = b_slot(a);
    if (b_guard(k)) return "R3";
    if (k == 3) return "R4";
    if (k == 5) return "R5";
    if (k == 8) return "R9";
    if (k == 4 || k == 6) return "R10";
    return "R2";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at the edge, check the lock after
  task automatic step(input logic sel, input logic wr, input logic [5:0] a, input logic [15:0] d,
                      input logic ext, input logic cv, input logic [15:0] cd);
    int k;
    logic lk, arm;
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
    ext_pwr_up = ext; cvt_valid = cv; cvt_data = cd;
    @(posedge clk);
    k = b_slot(a);
    lk = b_lock();
    arm = bm[3][0];
    if (sel && wr && k >= 0 && b_mask(k) != 16'h0 && !(arm && b_guard(k)) && !(lk && k == 3))
      bm[k] = (bm[k] & ~b_mask(k)) | (d & b_mask(k));
    if (cv) bm[8] = cd;
    e3 = e2; e2 = e1; e1 = ext;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; cvt_valid = 1'b0;
    chk(cvt_locked === b_lock(), bm[0][0] ? "R7" : "R6", {15'b0, cvt_locked}, {15'b0, b_lock()});
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    step(1'b1, 1'b1, a, d, ext_pwr_up, 1'b0, 16'h0);
  endtask

  task automatic idle(input logic ext);
    step(1'b0, 1'b0, 6'h0, 16'h0, ext, 1'b0, 16'h0);
  endtask

  task automatic rd(input logic [5:0] a, input string req);
    logic [15:0] exp;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    exp = b_read(a);
    chk(bus_rdata === exp, req, bus_rdata, exp);
    bus_sel = 1'b0;
    #1;
  endtask

  task automatic rd_exp(input logic [5:0] a, input logic [15:0] exp, input string req);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(bus_rdata === exp, req, bus_rdata, exp);
    bus_sel = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] picks [19];
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < 14; k++) bm[k] = b_reset(k);
    for (int k = 0; k < 8; k++) picks[k] = 6'(16 + 2 * k);
    picks[8] = 6'h22; picks[9] = 6'h24; picks[10] = 6'h26; picks[11] = 6'h28;
    picks[12] = 6'h0C; picks[13] = 6'h0E; picks[14] = 6'h00; picks[15] = 6'h20;
    picks[16] = 6'h2A; picks[17] = 6'h13; picks[18] = 6'h3E;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values, read with literal expectations
    rd_exp(6'h10, 16'h8001, "R1");
    rd_exp(6'h1C, 16'h0019, "R1");
    rd_exp(6'h1E, 16'h000F, "R1");
    rd_exp(6'h0C, 16'h0110, "R1");
    rd_exp(6'h0E, 16'hBB10, "R1");
    rd_exp(6'h16, 16'h0000, "R1");
    rd_exp(6'h24, 16'h0000, "R1");
    chk(cvt_locked === 1'b0, "R1", {15'b0, cvt_locked}, 16'h0);

    // R2: reserved and odd offsets
    wr(6'h20, 16'hFFFF);
    rd_exp(6'h20, 16'h0000, "R2");
    wr(6'h11, 16'hFFFF);
    rd_exp(6'h11, 16'h0000, "R2");
    rd_exp(6'h10, 16'h8001, "R2");

    // R5/R10: ctl5 lock bit not writable, upper bits are
    wr(6'h1A, 16'hFFFF);
    rd_exp(6'h1A, 16'hFFFE, "R5");
    wr(6'h1C, 16'h00A5);
    rd_exp(6'h1C, 16'h00A5, "R10");

    // R6: software source
    wr(6'h10, 16'h8000);
    wr(6'h16, 16'h0001);
    wr(6'h12, 16'h1111);
    rd_exp(6'h12, 16'h0000, "R3");
    wr(6'h18, 16'h0001);
    chk(cvt_locked === 1'b1, "R6", {15'b0, cvt_locked}, 16'h1);
    rd_exp(6'h1A, 16'hFFFF, "R5");
    wr(6'h16, 16'h0000);
    rd_exp(6'h16, 16'h0001, "R4");
    wr(6'h1C, 16'h005A);
    rd_exp(6'h1C, 16'h005A, "R10");
    wr(6'h28, 16'hCAFE);
    rd_exp(6'h28, 16'h0000, "R3");

    // R8: unlock order
    wr(6'h18, 16'h0000);
    chk(cvt_locked === 1'b0, "R8", {15'b0, cvt_locked}, 16'h0);
    wr(6'h16, 16'h0000);
    rd_exp(6'h16, 16'h0000, "R8");
    wr(6'h12, 16'h1234);
    rd_exp(6'h12, 16'h1234, "R8");

    // R7: external source, three-edge latency
    wr(6'h10, 16'h8001);
    wr(6'h16, 16'h0001);
    idle(1'b1);
    chk(cvt_locked === 1'b0, "R7", {15'b0, cvt_locked}, 16'h0);
    idle(1'b1);
    chk(cvt_locked === 1'b0, "R7", {15'b0, cvt_locked}, 16'h0);
    idle(1'b1);
    chk(cvt_locked === 1'b1, "R7", {15'b0, cvt_locked}, 16'h1);
    wr(6'h16, 16'h0000);
    rd_exp(6'h16, 16'h0001, "R4");
    idle(1'b0);
    idle(1'b0);
    chk(cvt_locked === 1'b1, "R8", {15'b0, cvt_locked}, 16'h1);
    idle(1'b0);
    chk(cvt_locked === 1'b0, "R8", {15'b0, cvt_locked}, 16'h0);
    wr(6'h16, 16'h0000);
    rd_exp(6'h16, 16'h0000, "R8");

    // R9: sample word
    step(1'b0, 1'b0, 6'h0, 16'h0, 1'b0, 1'b1, 16'hBEEF);
    rd_exp(6'h22, 16'hBEEF, "R9");
    wr(6'h22, 16'h0000);
    rd_exp(6'h22, 16'hBEEF, "R9");

    // seeded random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [5:0]  a;
      logic [15:0] d;
      logic        ext;
      bit          w;
      a = picks[$urandom_range(0, 18)];
      if ($urandom_range(0, 3) == 0) a = picks[$urandom_range(0, 4)];
      d = 16'($urandom);
      ext = ($urandom_range(0, 7) == 0) ? ~ext_pwr_up : ext_pwr_up;
      w = ($urandom_range(0, 9) < 7);
      step(1'b1, w, a, d, ext, ($urandom_range(0, 7) == 0), 16'($urandom));
      a = picks[$urandom_range(0, 18)];
      rd(a, b_tag(a));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule